// File: doc/BRIEF.md
# Display Status Register with Interrupt Request

This block holds the status and line-compare registers of a display controller and derives the single interrupt request that goes with them. The display sequencer supplies the current drawing phase (a two-bit mode) and the current line number; the block compares that line against a compare register that software can load, combines the phases and the match result with software-selected enable bits, and raises a one-cycle interrupt request whenever the combined condition first becomes true.

Software reaches both registers through a small read/write port: a one-bit select, a write strobe, write data and combinational read data. The status register returns the live mode, the live compare result and the enable bits; the compare register is plain read/write storage.

A strap input selects an optional behaviour of the older monochrome variant. When the strap is high, any write to the status register first loads all enables as ones for one cycle and only then the value that was written. As a result, a write made while any condition is present can raise an interrupt even if it enables nothing. With the strap low, the write lands directly.

Top module: `lcdstat_ctrl`

## Requirements
- R1: After reset the enable bits and the compare register are zero, the interrupt output is low, and a status read returns 0x84 when mode is 0 and the line is 0.
- R2: Status bits 1:0 always read the mode input. Writes to the status register never change these bits.
- R3: Status bit 2 reads 1 exactly while the line input equals the compare register. It follows line and compare changes with no clock delay.
- R4: Select 0 addresses the status register and select 1 the compare register. Status bit 7 always reads 1. The compare register reads back the last value written to it.
- R5: Status bits 6:3 are writable enables. Bit 3 enables mode 0, bit 4 enables mode 1, bit 5 enables mode 2, and bit 6 enables the line match. Mode 3 is never a source.
- R6: The enabled conditions are ORed into one internal line. The interrupt output is high for exactly one cycle, in the cycle after that line rises, and it does not pulse again while the line stays high.
- R7: With the strap low, a status write sets the enables to the written bits at the next clock edge, and it raises no interrupt unless the new enables select a present condition.
- R8: With the strap high, a status write sets all four enables for one cycle, and the written bits take effect one cycle later. Any write, including 0x00, made while mode is 0, 1 or 2 or while the line matches, therefore gives exactly one interrupt pulse.
- R9: With the strap high, a write made in mode 3 with no line match raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 status, 1 compare |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register |
| mode_i | input | 2 | Current drawing phase from the sequencer |
| line_i | input | LINE_W | Current line number from the sequencer |
| quirk_en_i | input | 1 | Strap that selects the monochrome write behaviour |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is a spurious pulse from a write whose value enables nothing. It needs the strap high, a present condition, and an internal line that was low just before the write. The stimulus first clears the enables with the strap low and lets the line settle. It then sets the mode and the line and makes the write. This is swept over every mode, match and no-match, both strap settings and several written values, and the pulses in a short window after each write are counted.

// File: rtl/lcdstat_pkg.sv
package lcdstat_pkg;
    localparam int DW     = 8;
    localparam int NSRC   = 4;
    localparam int EN_LSB = 3;
    localparam int EN_MSB = EN_LSB + NSRC - 1;

    localparam logic SEL_STATUS  = 1'b0;
    localparam logic SEL_COMPARE = 1'b1;

    typedef enum logic [1:0] {
        PH_HBLANK = 2'd0,
        PH_VBLANK = 2'd1,
        PH_SEARCH = 2'd2,
        PH_DRAW   = 2'd3
    } lcd_phase_e;
endpackage

// File: rtl/lcdstat_match.sv
module lcdstat_match #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] line_i,
    input  logic [LW-1:0] cmp_i,
    output logic          eq_o
);
    assign eq_o = (line_i == cmp_i);
endmodule

// File: rtl/lcdstat_srcsel.sv
module lcdstat_srcsel #(
    parameter int NS = 4
) (
    input  logic [1:0]    mode_i,
    input  logic          match_i,
    input  logic [NS-1:0] en_i,
    output logic          line_o
);
    logic [NS-1:0] cond;

    genvar g;
    generate
        for (g = 0; g < NS; g++) begin : g_src
            if (g == NS - 1) begin : g_match
                assign cond[g] = match_i;
            end else begin : g_phase
                assign cond[g] = (mode_i == 2'(g));
            end
        end
    endgenerate

    assign line_o = |(en_i & cond);
endmodule

// File: rtl/lcdstat_ctrl.sv
module lcdstat_ctrl
    import lcdstat_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rd_data_o,
    input  logic [1:0]        mode_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              quirk_en_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [NSRC-1:0]   en;
        logic [NSRC-1:0]   held;
        logic              held_vld;
        logic [LINE_W-1:0] cmp;
        logic              line_prev;
        logic              irq;
    } state_t;

    state_t s_q, s_d;
    logic   match;
    logic   line_now;
    logic   wr_stat, wr_cmp;

    // observation points for the bound checker
    logic [NSRC-1:0]   en_cur;
    logic [LINE_W-1:0] cmp_cur;
    logic              src_line;
    assign en_cur   = s_q.en;
    assign cmp_cur  = s_q.cmp;
    assign src_line = line_now;

    lcdstat_match #(.LW(LINE_W)) u_match (
        .line_i (line_i),
        .cmp_i  (s_q.cmp),
        .eq_o   (match)
    );

    lcdstat_srcsel #(.NS(NSRC)) u_src (
        .mode_i  (mode_i),
        .match_i (match),
        .en_i    (s_q.en),
        .line_o  (line_now)
    );

    assign wr_stat = wr_en_i && (addr_i == SEL_STATUS);
    assign wr_cmp  = wr_en_i && (addr_i == SEL_COMPARE);

    always_comb begin
        s_d = s_q;
        if (s_q.held_vld) begin
            s_d.en       = s_q.held;
            s_d.held_vld = 1'b0;
        end
        if (wr_stat) begin
            if (quirk_en_i) begin
                s_d.en       = '1;
                s_d.held     = wr_data_i[EN_MSB:EN_LSB];
                s_d.held_vld = 1'b1;
            end else begin
                s_d.en       = wr_data_i[EN_MSB:EN_LSB];
                s_d.held_vld = 1'b0;
            end
        end
        if (wr_cmp) begin
            s_d.cmp = wr_data_i[LINE_W-1:0];
        end
        s_d.line_prev = line_now;
        s_d.irq       = line_now & ~s_q.line_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (addr_i == SEL_STATUS) begin
            rd_data_o = {1'b1, s_q.en, match, mode_i};
        end else begin
            rd_data_o = DW'(s_q.cmp);
        end
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/lcdstat_ctrl_chk.sv
module lcdstat_ctrl_chk #(
    parameter int LINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_i,
    input logic              wr_en_i,
    input logic [7:0]        wr_data_i,
    input logic [7:0]        rd_data_o,
    input logic [1:0]        mode_i,
    input logic [LINE_W-1:0] line_i,
    input logic              quirk_en_i,
    input logic              irq_o,
    input logic [3:0]        en_cur,
    input logic [LINE_W-1:0] cmp_cur,
    input logic              src_line
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R6

    AST_IRQ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_line && !irq_o && !$past(src_line)) |=> irq_o); // R6

    AST_TOP_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 1'b0) |-> rd_data_o[7]); // R4

    AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 1'b0) |-> (rd_data_o[1:0] == mode_i)); // R2

    AST_MATCH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 1'b0) |-> (rd_data_o[2] == (line_i == cmp_cur))); // R3

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && !quirk_en_i) |=> (en_cur == $past(wr_data_i[6:3]))); // R7

    AST_QUIRK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && quirk_en_i) |=> (en_cur == 4'hF)); // R8
endmodule

bind lcdstat_ctrl lcdstat_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .mode_i     (mode_i),
    .line_i     (line_i),
    .quirk_en_i (quirk_en_i),
    .irq_o      (irq_o),
    .en_cur     (en_cur),
    .cmp_cur    (cmp_cur),
    .src_line   (src_line)
);

// File: tb/lcdstat_ctrl_test.sv
`timescale 1ns/1ps
module lcdstat_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] mode = 2'd0;
    logic [7:0] line = 8'd0;
    logic       quirk = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcdstat_ctrl #(.LINE_W(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wr_data_i  (wdata),
        .rd_data_o  (rdata),
        .mode_i     (mode),
        .line_i     (line),
        .quirk_en_i (quirk),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] v);
        @(negedge clk);
        addr  = sel;
        wdata = v;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts pulses seen at negedges over n cycles
    task automatic count_irq(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (irq) cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [7:0] exp;
        logic [7:0] vals [5];
        vals[0] = 8'h00; vals[1] = 8'h08; vals[2] = 8'h10;
        vals[3] = 8'h20; vals[4] = 8'h40;

        idle(2);
        // R1: reset state
        addr = 1'b0;
        #1;
        check(rdata == 8'h84, "R1 status", rdata, 8'h84);
        check(irq == 1'b0, "R1 irq", irq, 0);
        addr = 1'b1;
        #1;
        check(rdata == 8'h00, "R1 compare", rdata, 8'h00);
        addr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R4: compare read/write
        write_reg(1'b1, 8'h9A);
        addr = 1'b1;
        #1;
        check(rdata == 8'h9A, "R4 compare readback", rdata, 8'h9A);
        addr = 1'b0;
        // R3: match follows line immediately
        mode = 2'd3;
        line = 8'h9A;
        #1;
        check(rdata == 8'hC7 - 8'h40, "R3 match set", rdata, 8'h87);
        line = 8'h9B;
        #1;
        check(rdata == 8'h83, "R3 match clear", rdata, 8'h83);

        // R2: mode bits read-only, R5 enables readback
        mode = 2'd2;
        write_reg(1'b0, 8'hFF);
        #1;
        check(rdata == 8'hFA, "R2 mode read-only", rdata, 8'hFA);
        write_reg(1'b0, 8'h00);
        idle(2);

        // R8: quirk ones for one cycle, then written value
        mode  = 2'd3;
        idle(2);
        quirk = 1'b1;
        write_reg(1'b0, 8'h00);
        check(rdata == 8'hFB, "R8 ones window", rdata, 8'hFB);
        @(negedge clk);
        check(rdata == 8'h83, "R8 value lands", rdata, 8'h83);
        quirk = 1'b0;
        idle(2);

        // R6: edge-only pulse on mode entry
        write_reg(1'b0, 8'h08);
        idle(2);
        mode = 2'd0;
        count_irq(8, cnt);
        check(cnt == 1, "R6 single pulse", cnt, 1);
        mode = 2'd3;
        idle(2);
        mode = 2'd0;
        idle(1);
        check(irq == 1'b1, "R6 pulse one cycle after rise", irq, 1);
        write_reg(1'b0, 8'h00);
        idle(2);

        // R5 R7 R8 R9 sweep
        write_reg(1'b1, 8'h05);
        for (int q = 0; q < 2; q++) begin
            for (int m = 0; m < 4; m++) begin
                for (int mt = 0; mt < 2; mt++) begin
                    for (int vi = 0; vi < 5; vi++) begin
                        logic [3:0] cond;
                        logic [3:0] en;
                        int want;
                        quirk = 1'b0;
                        write_reg(1'b0, 8'h00);
                        idle(2);
                        mode = 2'(m);
                        line = (mt != 0) ? 8'h05 : 8'h06;
                        idle(2);
                        quirk = 1'(q);
                        cond = {mt[0], m == 2, m == 1, m == 0};
                        en = vals[vi][6:3];
                        if (q != 0) want = (cond != 4'h0) ? 1 : 0;
                        else want = ((en & cond) != 4'h0) ? 1 : 0;
                        write_reg(1'b0, vals[vi]);
                        count_irq(5, cnt);
                        if (q != 0 && cond == 4'h0)
                            check(cnt == want, "R9 no source", cnt, want);
                        else if (q != 0)
                            check(cnt == want, "R8 spurious", cnt, want);
                        else
                            check(cnt == want, "R7 direct", cnt, want);
                        exp = {1'b1, en, mt[0], 2'(m)};
                        check(rdata == exp, "R5 readback", rdata, exp);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule